// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This unit watches eight external interrupt pins and turns each one into an active-high request for a parent interrupt controller. Every pin first passes through a two-flop synchroniser. Its detection mode is then chosen by a 2-bit field in a packed sense register. There are four modes: active-low level, falling edge, rising edge and both edges.

In an edge mode, a detected edge sets a sticky bit in the status register, and that bit drives the pin's request output. Software acknowledges the event by writing 0 to the bit. In level mode the status bit follows the inverted synchronised pin, and the status register cannot be changed by software.

Software reaches the two registers over a single-cycle register port, which has an address, a write strobe, write data and combinational read data. A read issued in the cycle after a clear already returns the cleared value, so an event that has been handled does not come back.

Top module: `pin_irq_sense`

## Requirements
- R1: Each pin goes through a two-flop synchroniser whose flops reset to 1. A pin change set up before rising edge k reaches irq_o at rising edge k+2, not earlier.
- R2: The sense register is at offset 0x14, and pin n owns bits [2n+1:2n]. A write stores bits 15:0. A read returns those bits with bits 31:16 as zero.
- R3: Sense value 1 sets status bit n on a falling edge of the synchronised pin. Value 2 sets it on a rising edge. Value 3 sets it on either edge.
- R4: With sense value 0 (active-low level), status bit n equals the inverse of the synchronised pin one cycle later. Writes to the status register do not change it.
- R5: The status register is at offset 0x10, with bit n for pin n. In an edge mode, writing 0 to bit n clears it at the next clock edge, and a read in the following cycle returns the cleared value.
- R6: In an edge mode, writing 1 to a status bit leaves it unchanged. A set bit stays set until software clears it.
- R7: An edge detected in the same cycle as a clear of that bit leaves the bit set.
- R8: irq_o[n] is an active-high level equal to status bit n.
- R9: Reset clears all status bits and the sense register. Writes to any other offset have no effect, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 8 | Active-high requests to parent controller |

## Verification
The bench checks the exact three-edge latency from pin to request. A design with one synchroniser stage too many or too few asserts a cycle late or a cycle early. It writes 0 to a level-mode pin's status bit, where a design that accepts the clear would drop a request whose pin is still low. It also writes all ones to the status register, which a design treating 1 as a toggle or set would corrupt. Finally, it places a clear exactly in the cycle an edge is detected. A design that lets the clear win would lose that event, and the reference model compared on every clock would show the dropped request.

// File: rtl/pin_irq_pkg.sv
// Package: shared sense-mode encoding for the pin interrupt sense unit.
// Assumes: the encoding values are fixed by software and must not change.
package pin_irq_pkg;
    typedef enum logic [1:0] {
        SENSE_LEVEL_LOW = 2'd0,
        SENSE_FALL      = 2'd1,
        SENSE_RISE      = 2'd2,
        SENSE_BOTH      = 2'd3
    } sense_mode_e;
endpackage

// File: rtl/pin_irq_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes: pins are idle high, so every stage resets to 1 so that a level-low
// sense never sees a false request right after reset.
module pin_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each pin one stage further toward the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '1;
                else if (s == 0)
                    stage_q[s] <= async_i;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_cell.sv
// Module: per-pin detector and status bit.
// Assumes: sync_i is already in the clock domain; clr_i is a one-cycle clear
// request from the register port.
module pin_irq_cell
    import pin_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sense_i,
    input  logic       sync_i,
    input  logic       clr_i,
    output logic       st_o
);
    sense_mode_e mode;
    logic        prev_q;
    logic        evt;
    logic        st_q;

    assign mode = sense_mode_e'(sense_i);

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_i;
    end

    // Decide whether the selected edge occurred this cycle.
    always_comb begin
        unique case (mode)
            SENSE_FALL:  evt = prev_q & ~sync_i;
            SENSE_RISE:  evt = ~prev_q & sync_i;
            SENSE_BOTH:  evt = prev_q ^ sync_i;
            default:     evt = 1'b0;
        endcase
    end

    // Status: follows pin in level mode, sticky with clear in edge modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= 1'b0;
        else if (mode == SENSE_LEVEL_LOW)
            st_q <= ~sync_i;
        else
            st_q <= evt | (st_q & ~clr_i);
    end

    assign st_o = st_q;

    assert_level_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LEVEL_LOW) |=> (st_q == !$past(sync_i)));
    assert_clear_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SENSE_LEVEL_LOW && clr_i && !evt) |=> !st_q);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SENSE_LEVEL_LOW && st_q && !clr_i) |=> st_q);
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SENSE_LEVEL_LOW && evt) |=> st_q);
endmodule

// File: rtl/pin_irq_regs.sv
// Module: sense register, status-clear decode and read mux.
// Assumes: single-cycle port; reads are combinational from bus_addr.
module pin_irq_regs #(
    parameter int              NUM_PINS   = 8,
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] SENSE_OFS  = 8'h14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_PINS-1:0]   status_i,
    output logic [2*NUM_PINS-1:0] sense_o,
    output logic [NUM_PINS-1:0]   clr_o,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int SENSE_W = 2 * NUM_PINS;

    logic [SENSE_W-1:0] sense_q;
    logic               wr_sense;
    logic               wr_status;

    assign wr_sense  = bus_wr && (bus_addr == SENSE_OFS);
    assign wr_status = bus_wr && (bus_addr == STATUS_OFS);

    // Hold the packed per-pin sense fields.
    always_ff @(posedge clk) begin
        if (!rst_n)        sense_q <= '0;
        else if (wr_sense) sense_q <= bus_wdata[SENSE_W-1:0];
    end

    // A written zero requests a clear; ones are ignored.
    assign clr_o   = wr_status ? ~bus_wdata[NUM_PINS-1:0] : '0;
    assign sense_o = sense_q;

    // Return the addressed register, zero elsewhere.
    always_comb begin
        if (bus_addr == STATUS_OFS)
            bus_rdata = {{(DATA_W-NUM_PINS){1'b0}}, status_i};
        else if (bus_addr == SENSE_OFS)
            bus_rdata = {{(DATA_W-SENSE_W){1'b0}}, sense_q};
        else
            bus_rdata = '0;
    end

    assert_sense_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sense |=> (sense_o == $past(bus_wdata[SENSE_W-1:0])));
    assert_other_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_sense) |=> $stable(sense_o));
endmodule

// File: rtl/pin_irq_sense.sv
// Module: top of the external pin interrupt sense unit.
// Assumes: pins are asynchronous and idle high; the parent controller takes
// active-high level requests.
module pin_irq_sense #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] irq_o
);
    localparam int SENSE_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] clr;
    logic [SENSE_W-1:0]  sense;

    pin_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    pin_irq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .status_i  (status),
        .sense_o   (sense),
        .clr_o     (clr),
        .bus_rdata (bus_rdata)
    );

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            pin_irq_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .sense_i (sense[2*n +: 2]),
                .sync_i  (pin_sync[n]),
                .clr_i   (clr[n]),
                .st_o    (status[n])
            );
        end
    endgenerate

    assign irq_o = status;

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

// File: tb/pin_irq_sense_bench.sv
module pin_irq_sense_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STATUS = 8'h10;
    localparam logic [7:0] A_SENSE  = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'hFF;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_sense u_pin_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Behavioural reference: history queue of sampled pins plus model registers.
    logic [7:0]  hist[$];
    logic [7:0]  m_st = '0;
    logic [15:0] m_sense = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{8'hFF, 8'hFF, 8'hFF};
            m_st = '0;
            m_sense = '0;
        end else begin
            logic [7:0] cur, old, nst;
            cur = hist[1];
            old = hist[2];
            for (int n = 0; n < 8; n++) begin
                int mode;
                bit ev, cl;
                mode = int'(m_sense[2*n +: 2]);
                ev = (mode == 1 && old[n] && !cur[n]) ||
                     (mode == 2 && !old[n] && cur[n]) ||
                     (mode == 3 && old[n] != cur[n]);
                cl = bus_wr && bus_addr == A_STATUS && !bus_wdata[n];
                if (mode == 0) nst[n] = !cur[n];
                else           nst[n] = ev || (m_st[n] && !cl);
            end
            m_st = nst;
            if (bus_wr && bus_addr == A_SENSE) m_sense = bus_wdata[15:0];
            hist.push_front(pin_i);
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare the request outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) check("R8 model", {24'h0, irq_o}, {24'h0, m_st});
    end

    task automatic tick(int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R9 reset irq", {24'h0, irq_o}, 32'h0);
        rd_check("R9 reset status", A_STATUS, 32'h0);
        rd_check("R2 reset sense", A_SENSE, 32'h0);

        // pins 0,4 level; 1,5 falling; 2,6 rising; 3,7 both
        wr(A_SENSE, 32'hABCD_E4E4);
        rd_check("R2 sense readback", A_SENSE, 32'h0000_E4E4);
        tick(3);
        check("R4 level idle", {24'h0, irq_o}, 32'h0);

        pin_i[0] = 1'b0;
        tick(2);
        check("R1 not yet", {31'h0, irq_o[0]}, 32'h0);
        tick(1);
        check("R1 latency R4 level", {31'h0, irq_o[0]}, 32'h1);
        wr(A_STATUS, 32'h0);
        rd_check("R4 clear ignored", A_STATUS, 32'h01);
        pin_i[0] = 1'b1;
        tick(3);
        check("R4 level release", {24'h0, irq_o}, 32'h0);

        pin_i = 8'h11;
        tick(3);
        check("R3 falling/both", {24'h0, irq_o}, 32'hAA);
        rd_check("R8 status read", A_STATUS, 32'hAA);
        wr(A_STATUS, 32'hFF);
        rd_check("R6 write one", A_STATUS, 32'hAA);
        tick(2);
        rd_check("R6 sticky", A_STATUS, 32'hAA);

        pin_i = 8'hFF;
        tick(3);
        rd_check("R3 rising/both", A_STATUS, 32'hEE);
        wr(A_STATUS, 32'hFD);
        rd_check("R5 single clear", A_STATUS, 32'hEC);
        wr(A_STATUS, 32'h00);
        rd_check("R5 clear all", A_STATUS, 32'h00);

        // clear write lands on the edge that latches pin 3's falling edge
        pin_i[3] = 1'b0;
        tick(2);
        wr(A_STATUS, 32'h00);
        rd_check("R7 event wins", A_STATUS, 32'h08);
        wr(A_STATUS, 32'h00);
        rd_check("R5 clear after", A_STATUS, 32'h00);

        pin_i[3] = 1'b1;
        tick(3);
        wr(8'h18, 32'h0);
        rd_check("R9 other offset write", A_STATUS, 32'h08);
        rd_check("R9 other offset read", 8'h18, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd_check("R9 sense untouched", A_SENSE, 32'h0000_E4E4);

        tick(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule